// File: doc/BRIEF.md
# Transmit Frame Descriptor Queue

This block is the transmit half of a frame DMA engine. Host software queues a frame by writing one 32-bit request word. The word carries the byte offset of a descriptor inside the transmit buffer window in bits [23:0], and a rounded transfer length in bits [31:24]. Pending requests wait in a small internal FIFO. The block serves them one at a time, in arrival order.

For each request the block reads the descriptor header through a single-outstanding memory read port. It then fetches the payload one 32-bit word at a time and streams it out as bytes, with a two-bit output port selector and backpressure. Once the last byte has been accepted, it writes a completion flag into the descriptor's sent word.

Three counters are visible at the ports: the number of pending requests, the number of completed frames and the number of dropped requests. Register writes can clear the pending queue and the frame counter.

Top module: `txq_top`

## Requirements
- R1: A write to the queue register (byte offset 0x00) enqueues the descriptor offset from bits [23:0]. The length field in bits [31:24] has no effect on which bytes are sent or how many.
- R2: The first header word is read at the descriptor offset. Bytes 0 and 1 of that word give the payload length, least significant byte first. Bits [17:16] (the low two bits of byte 2) drive `txPortSel` for the whole frame: bit 0 selects port 0 and bit 1 selects port 1.
- R3: The payload is read from offset+16 upward, one word per read, with at most one read outstanding. Each word leaves as bytes, least significant byte first. Exactly the header length in bytes is sent, and `txLast` marks the final byte.
- R4: A header length above MAX_PAYLOAD (default 2024) is clamped to MAX_PAYLOAD bytes.
- R5: A header length of zero sends no bytes, but the completion write is still made.
- R6: After the final byte is accepted, a single write of 0x00000001 goes to offset+4, and `frameCount` increments by one.
- R7: Requests are served in the order they were written, and each frame finishes before the next header read starts.
- R8: A queue write that arrives while FIFO_DEPTH requests are pending is discarded. Fullness is judged before any removal in the same cycle. `dropCount` increments and `fillLevel` is unchanged.
- R9: Any write to the flush register (byte offset 0x08, eight above the queue register) empties the pending queue. A frame already in flight still completes.
- R10: `fillLevel` equals the number of pending requests. Writing zero to the level register (0x0C) empties the queue. A nonzero write there has no effect.
- R11: Writing zero to the frame-count register (0x10) clears `frameCount`, and this takes priority over an increment in the same cycle. A nonzero write there has no effect.
- R12: While `txValid` is high and `txReady` is low, `txValid`, `txData` and `txPortSel` hold steady.
- R13: After reset, all counters are zero and `txValid`, `memRdEn` and `memWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte offset |
| regWrData | input | 32 | Register write data |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | 24 | Read byte address (word aligned for payload) |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data, little-endian bytes |
| memWrEn | output | 1 | Completion write strobe |
| memWrAddr | output | 24 | Completion write byte address |
| memWrData | output | 32 | Completion write data |
| txValid | output | 1 | Output byte valid |
| txReady | input | 1 | Output byte accepted |
| txData | output | 8 | Output byte |
| txLast | output | 1 | Final byte of frame |
| txPortSel | output | 2 | Port selector from header |
| fillLevel | output | $clog2(FIFO_DEPTH+1) | Pending request count |
| frameCount | output | CNT_W (32) | Completed frames |
| dropCount | output | DROP_W (16) | Discarded requests |

## Verification
The bench builds the block with FIFO_DEPTH set to 4. With that depth, a handful of queue writes issued during one long frame fill the FIFO, so overflow drops, flushing and level clearing can all be reached. MAX_PAYLOAD stays at its default of 2024, so a 3000-byte header length exercises the clamp within a few thousand cycles. Stalls from a periodic `txReady` pattern check that the output holds under backpressure across word boundaries.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int OFF_W      = 24;
  localparam int REG_ADDR_W = 5;
  localparam int HDR_BYTES  = 16;
  localparam int SENT_OFS   = 4;

  localparam logic [REG_ADDR_W-1:0] REG_QUEUE  = 5'h00;
  localparam logic [REG_ADDR_W-1:0] REG_FLUSH  = 5'h08;
  localparam logic [REG_ADDR_W-1:0] REG_LEVEL  = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] REG_FRAMES = 5'h10;

  typedef struct packed {
    logic rdHdr;
    logic rdPay;
    logic loadHdr;
    logic loadWord;
    logic nextByte;
    logic complete;
  } txqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HDR,
    ST_RD_PAY,
    ST_WAIT_PAY,
    ST_STREAM,
    ST_DONE
  } txqState_t;

endpackage

// File: rtl/txq_req_fifo.sv
module txq_req_fifo #(
  parameter int DEPTH = 8,
  parameter int W = 24,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  input  logic             flush,
  output logic [W-1:0]     headData,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] cnt;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt == LVL_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign level  = cnt;
  assign headData = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      cnt <= cnt + LVL_W'(doPush) - LVL_W'(doPop);
    end
  end

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !flush) |=> level == $past(level));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       qEmpty,
  input  logic       memRdValid,
  input  logic       hdrLenZero,
  input  logic       lastByte,
  input  logic       laneLast,
  input  logic       txReady,
  output txqStrobe_t st,
  output logic       qPop,
  output logic       streaming
);

  txqState_t state, nextState;

  always_comb begin
    st        = '0;
    qPop      = 1'b0;
    streaming = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (!qEmpty) begin
        st.rdHdr  = 1'b1;
        qPop      = 1'b1;
        nextState = ST_WAIT_HDR;
      end
      ST_WAIT_HDR: if (memRdValid) begin
        st.loadHdr = 1'b1;
        nextState  = hdrLenZero ? ST_DONE : ST_RD_PAY;
      end
      ST_RD_PAY: begin
        st.rdPay  = 1'b1;
        nextState = ST_WAIT_PAY;
      end
      ST_WAIT_PAY: if (memRdValid) begin
        st.loadWord = 1'b1;
        nextState   = ST_STREAM;
      end
      ST_STREAM: begin
        streaming = 1'b1;
        if (txReady) begin
          st.nextByte = 1'b1;
          if (lastByte)      nextState = ST_DONE;
          else if (laneLast) nextState = ST_RD_PAY;
        end
      end
      ST_DONE: begin
        st.complete = 1'b1;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdHdr || st.rdPay) |=> !(st.rdHdr || st.rdPay));

  // R6
  complete_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.complete |=> !st.complete);

  // R7
  pop_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    qPop |=> !qPop && !streaming);

endmodule

// File: rtl/txq_dpath.sv
module txq_dpath
  import txq_pkg::*;
#(
  parameter int MAX_PAYLOAD = 2024,
  parameter int CNT_W = 32,
  parameter int DROP_W = 16,
  localparam int LEN_W = $clog2(MAX_PAYLOAD + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  txqStrobe_t            st,
  input  logic                  streaming,
  input  logic                  txReady,
  input  logic [OFF_W-1:0]      headOff,
  input  logic                  fifoFull,
  input  logic [31:0]           memRdData,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [31:0]           regWrData,
  output logic                  pushReq,
  output logic [OFF_W-1:0]      pushOff,
  output logic                  flushReq,
  output logic [OFF_W-1:0]      rdAddr,
  output logic [OFF_W-1:0]      wrAddr,
  output logic [7:0]            txData,
  output logic [1:0]            txPort,
  output logic                  hdrLenZero,
  output logic                  lastByte,
  output logic                  laneLast,
  output logic [CNT_W-1:0]      frameCount,
  output logic [DROP_W-1:0]     dropCount
);

  logic [OFF_W-1:0] baseOff, payPtr;
  logic [LEN_W-1:0] remain, clampLen;
  logic [1:0]       lane;
  logic [31:0]      word;
  logic             frameClr, wrZero;

  assign wrZero   = (regWrData == 32'd0);
  assign pushReq  = regWrEn && (regAddr == REG_QUEUE);
  assign pushOff  = regWrData[OFF_W-1:0];
  assign flushReq = regWrEn && ((regAddr == REG_FLUSH) ||
                                ((regAddr == REG_LEVEL) && wrZero));
  assign frameClr = regWrEn && (regAddr == REG_FRAMES) && wrZero;

  assign hdrLenZero = (memRdData[15:0] == 16'd0);
  assign clampLen = (32'(memRdData[15:0]) > 32'(MAX_PAYLOAD)) ?
                    LEN_W'(MAX_PAYLOAD) : LEN_W'(memRdData[15:0]);

  assign lastByte = (remain == LEN_W'(1));
  assign laneLast = (lane == 2'd3);
  assign rdAddr   = st.rdHdr ? headOff : payPtr;
  assign wrAddr   = baseOff + OFF_W'(SENT_OFS);
  assign txData   = word[{lane, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseOff <= '0;
      payPtr  <= '0;
      remain  <= '0;
      lane    <= '0;
      word    <= '0;
      txPort  <= '0;
    end else begin
      if (st.rdHdr) baseOff <= headOff;
      if (st.loadHdr) begin
        remain <= clampLen;
        txPort <= memRdData[17:16];
        payPtr <= baseOff + OFF_W'(HDR_BYTES);
      end
      if (st.loadWord) begin
        word   <= memRdData;
        lane   <= '0;
        payPtr <= payPtr + OFF_W'(4);
      end
      if (st.nextByte) begin
        remain <= remain - 1'b1;
        lane   <= lane + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCount <= '0;
      dropCount  <= '0;
    end else begin
      if (frameClr)         frameCount <= '0;
      else if (st.complete) frameCount <= frameCount + 1'b1;
      if (pushReq && fifoFull) dropCount <= dropCount + 1'b1;
    end
  end

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (streaming && !txReady) |=> $stable(txData) && $stable(txPort));

  // R6
  frame_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.complete && !frameClr) |=> frameCount == $past(frameCount) + 1'b1);

  // R8
  drop_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && fifoFull) |=> dropCount == $past(dropCount) + 1'b1);

  // R3
  no_empty_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    streaming |-> remain != '0);

endmodule

// File: rtl/txq_top.sv
module txq_top
  import txq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int MAX_PAYLOAD = 2024,
  parameter int CNT_W = 32,
  parameter int DROP_W = 16,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [31:0]           regWrData,
  output logic                  memRdEn,
  output logic [OFF_W-1:0]      memRdAddr,
  input  logic                  memRdValid,
  input  logic [31:0]           memRdData,
  output logic                  memWrEn,
  output logic [OFF_W-1:0]      memWrAddr,
  output logic [31:0]           memWrData,
  output logic                  txValid,
  input  logic                  txReady,
  output logic [7:0]            txData,
  output logic                  txLast,
  output logic [1:0]            txPortSel,
  output logic [LVL_W-1:0]      fillLevel,
  output logic [CNT_W-1:0]      frameCount,
  output logic [DROP_W-1:0]     dropCount
);

  txqStrobe_t       st;
  logic             qPop, qFull, qEmpty, pushReq, flushReq, streaming;
  logic             hdrLenZero, lastByte, laneLast;
  logic [OFF_W-1:0] pushOff, headOff;

  txq_req_fifo #(.DEPTH(FIFO_DEPTH), .W(OFF_W)) i_fifo (
    .clk(clk), .rstN(rstN), .push(pushReq), .pushData(pushOff),
    .pop(qPop), .flush(flushReq), .headData(headOff),
    .level(fillLevel), .full(qFull), .empty(qEmpty)
  );

  txq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .qEmpty(qEmpty), .memRdValid(memRdValid),
    .hdrLenZero(hdrLenZero), .lastByte(lastByte), .laneLast(laneLast),
    .txReady(txReady), .st(st), .qPop(qPop), .streaming(streaming)
  );

  txq_dpath #(.MAX_PAYLOAD(MAX_PAYLOAD), .CNT_W(CNT_W), .DROP_W(DROP_W)) i_dpath (
    .clk(clk), .rstN(rstN), .st(st), .streaming(streaming), .txReady(txReady),
    .headOff(headOff), .fifoFull(qFull), .memRdData(memRdData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .pushReq(pushReq), .pushOff(pushOff), .flushReq(flushReq),
    .rdAddr(memRdAddr), .wrAddr(memWrAddr), .txData(txData), .txPort(txPortSel),
    .hdrLenZero(hdrLenZero), .lastByte(lastByte), .laneLast(laneLast),
    .frameCount(frameCount), .dropCount(dropCount)
  );

  assign memRdEn   = st.rdHdr | st.rdPay;
  assign memWrEn   = st.complete;
  assign memWrData = 32'h0000_0001;
  assign txValid   = streaming;
  assign txLast    = streaming & lastByte;

endmodule

// File: tb/test_txq_top.sv
`timescale 1ns/1ps
module test_txq_top;

  localparam int DEPTH = 4;
  localparam int MAXP  = 2024;
  localparam int MEMSZ = 16384;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        memRdEn, memWrEn, memRdValid;
  logic [23:0] memRdAddr, memWrAddr;
  logic [31:0] memRdData, memWrData;
  logic        txValid, txLast;
  logic        txReady = 1'b1;
  logic [7:0]  txData;
  logic [1:0]  txPortSel;
  logic [2:0]  fillLevel;
  logic [31:0] frameCount;
  logic [15:0] dropCount;

  always #5 clk = ~clk;

  txq_top #(.FIFO_DEPTH(DEPTH), .MAX_PAYLOAD(MAXP)) i_txq_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .txValid(txValid),
    .txReady(txReady), .txData(txData), .txLast(txLast),
    .txPortSel(txPortSel), .fillLevel(fillLevel), .frameCount(frameCount),
    .dropCount(dropCount)
  );

  byte unsigned mem [MEMSZ];
  int  nChecks = 0;
  int  nFails = 0;
  int  cyc = 0;
  int  readyMode = 0;
  bit  done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] rdWord(input logic [23:0] a);
    int b = int'(a) % MEMSZ;
    return {mem[(b+3)%MEMSZ], mem[(b+2)%MEMSZ], mem[(b+1)%MEMSZ], mem[b]};
  endfunction

  always @(posedge clk) begin
    if (!rstN) memRdValid <= 1'b0;
    else begin
      memRdValid <= memRdEn;
      if (memRdEn) memRdData <= rdWord(memRdAddr);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (readyMode == 0) txReady = 1'b1;
    else txReady = ((cyc % 3) != 1);
  end

  // ---------------- reference model ----------------
  int unsigned  mq[$];
  byte unsigned expBytes[$];
  bit           mBusy = 0;
  int unsigned  mBase = 0;
  int           mSent = 0;
  logic [1:0]   mPort = 0;
  int unsigned  mFrames = 0;
  int unsigned  mDrop = 0;
  bit           prevStall = 0;
  logic [7:0]   prevData;
  logic [1:0]   prevPort;

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(fillLevel == mq.size(), "R10 fill level", fillLevel, mq.size());
      check(dropCount == mDrop, "R8 drop count", dropCount, mDrop);
      check(frameCount == mFrames, "R6 frame count", frameCount, mFrames);
      if (prevStall) begin
        check(txValid && txData == prevData && txPortSel == prevPort,
              "R12 hold under stall", {txValid, txData}, {1'b1, prevData});
      end
      prevStall = 0;
      if (memRdEn && !mBusy) begin
        int b;
        int unsigned hl;
        check(mq.size() > 0, "R7 header read with queue", mq.size(), 1);
        if (mq.size() > 0) begin
          check(memRdAddr == mq[0][23:0], "R7 order / R1 offset", memRdAddr, mq[0]);
          mBase = mq.pop_front();
        end
        b = int'(mBase);
        hl = {mem[(b+1)%MEMSZ], mem[b%MEMSZ]};
        if (hl > MAXP) hl = MAXP;
        mPort = mem[(b+2)%MEMSZ][1:0];
        expBytes.delete();
        for (int i = 0; i < int'(hl); i++) expBytes.push_back(mem[(b+16+i)%MEMSZ]);
        mSent = 0;
        mBusy = 1;
      end else if (memRdEn) begin
        check(memRdAddr == 24'(mBase + 16 + mSent), "R3 payload address",
              memRdAddr, mBase + 16 + mSent);
      end
      if (txValid) begin
        check(mBusy && expBytes.size() > 0, "R3 unexpected byte", expBytes.size(), 1);
        if (txReady && expBytes.size() > 0) begin
          check(txData == expBytes[0], "R3 byte value", txData, expBytes[0]);
          check(txPortSel == mPort, "R2 port select", txPortSel, mPort);
          check(txLast == (expBytes.size() == 1), "R3 last marker", txLast, expBytes.size() == 1);
          void'(expBytes.pop_front());
          mSent++;
        end else if (!txReady) begin
          prevStall = 1;
          prevData = txData;
          prevPort = txPortSel;
        end
      end
      if (memWrEn) begin
        check(mBusy && expBytes.size() == 0, "R6 completion after last byte", expBytes.size(), 0);
        check(memWrAddr == 24'(mBase + 4), "R6 completion address", memWrAddr, mBase + 4);
        check(memWrData == 32'h1, "R6 completion data", memWrData, 1);
        mem[(memWrAddr + 0) % MEMSZ] = memWrData[7:0];
        mBusy = 0;
        if (!(regWrEn && regAddr == 5'h10 && regWrData == 0)) mFrames++;
      end
      if (regWrEn) begin
        case (regAddr)
          5'h00: if (mq.size() >= DEPTH) mDrop++; else mq.push_back(regWrData[23:0]);
          5'h08: mq.delete();
          5'h0C: if (regWrData == 0) mq.delete();
          5'h10: if (regWrData == 0) mFrames = 0;
          default: ;
        endcase
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic setDesc(input int off, input int len, input int port, input int seed);
    mem[off] = len[7:0]; mem[off+1] = len[15:8];
    mem[off+2] = port[7:0]; mem[off+3] = 8'h01;
    for (int i = 4; i < 16; i++) mem[off+i] = 8'h00;
    for (int i = 0; i < 2100; i++) mem[(off+16+i)%MEMSZ] = 8'((off >> 4) + i*7 + seed);
  endtask

  task automatic drain();
    @(negedge clk);
    while (mBusy || mq.size() != 0 || memRdEn) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(fillLevel == 0 && frameCount == 0 && dropCount == 0, "R13 counters after reset",
          {fillLevel, frameCount[7:0], dropCount[7:0]}, 0);
    check(!txValid && !memRdEn && !memWrEn, "R13 outputs idle after reset",
          {txValid, memRdEn, memWrEn}, 0);

    // R2 R3 short frame, port 0
    setDesc(32'h100, 5, 1, 3);
    regWrite(5'h00, {8'h18, 24'h000100});
    drain();
    check(mem[16'h104][0] == 1'b1, "R6 sent flag in descriptor", mem[16'h104], 1);
    check(frameCount == 1, "R6 one frame", frameCount, 1);

    // R12 backpressure, port 1, word-multiple length
    readyMode = 1;
    setDesc(32'h900, 8, 2, 11);
    regWrite(5'h00, {8'h18, 24'h000900});
    drain();
    check(frameCount == 2, "R12 frame done under stalls", frameCount, 2);

    // R5 zero length
    setDesc(32'h1100, 0, 1, 0);
    regWrite(5'h00, {8'h10, 24'h001100});
    drain();
    check(mem[16'h1104][0] == 1'b1, "R5 zero-length completion", mem[16'h1104], 1);

    // R4 clamp and R1 length field ignored
    readyMode = 0;
    setDesc(32'h1200, 3000, 1, 5);
    regWrite(5'h00, {8'h03, 24'h001200});
    drain();
    check(frameCount == 4, "R4 clamped frame done", frameCount, 4);

    // R8 overflow, R9 flush
    setDesc(32'h2000, 600, 2, 9);
    regWrite(5'h00, {8'h00, 24'h002000});
    regWrite(5'h00, 32'h0000_2800);
    regWrite(5'h00, 32'h0000_2900);
    regWrite(5'h00, 32'h0000_2A00);
    regWrite(5'h00, 32'h0000_2B00);
    regWrite(5'h00, 32'h0000_2C00);
    regWrite(5'h00, 32'h0000_2D00);
    check(fillLevel == DEPTH, "R8 level at full", fillLevel, DEPTH);
    check(dropCount == 2, "R8 drops counted", dropCount, 2);
    regWrite(5'h08, 32'h1);
    check(fillLevel == 0, "R9 flush empties queue", fillLevel, 0);
    drain();
    check(frameCount == 5, "R9 in-flight frame completes", frameCount, 5);

    // R10 level register
    regWrite(5'h00, 32'h0000_2000);
    regWrite(5'h00, 32'h0000_2800);
    regWrite(5'h00, 32'h0000_2900);
    regWrite(5'h0C, 32'h5);
    check(fillLevel == 2, "R10 nonzero level write ignored", fillLevel, 2);
    regWrite(5'h0C, 32'h0);
    check(fillLevel == 0, "R10 zero write empties", fillLevel, 0);
    drain();

    // R11 frame counter clear
    regWrite(5'h10, 32'h7);
    check(frameCount == 6, "R11 nonzero write ignored", frameCount, 6);
    regWrite(5'h10, 32'h0);
    check(frameCount == 0, "R11 zero write clears", frameCount, 0);

    // R7 back-to-back order
    setDesc(32'h3000, 6, 1, 21);
    setDesc(32'h3100, 3, 2, 22);
    regWrite(5'h00, 32'h0000_3000);
    regWrite(5'h00, 32'h0000_3100);
    regWrite(5'h00, 32'h0000_0100);
    drain();
    check(frameCount == 3, "R7 all queued frames served", frameCount, 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule